// File: doc/BRIEF.md
# Clock Domain Sleep/Wake Controller

This block decides whether the clocks of one clock domain run or are stopped. Software writes a two-bit transition-control field in a 32-bit register. The field selects one of three modes:

- **stay-on** never lets the domain go to sleep.
- **force-off** sends the domain to sleep.
- **force-on** wakes the domain.

A four-state machine (running, stopping, idle, starting) moves the domain between its active and inactive conditions. It drives one clock-enable output for each clock input. It advances out of a transition phase only when every clock has returned its gate or ungate acknowledge level. The acknowledges come from external gating cells.

The same register reports one activity bit for each clock. An activity bit reads 0 only when the domain is settled in the idle state. The block has two resets. A cold reset clears everything. A warm reset returns the state machine to the starting phase, so the domain comes back awake. It keeps the control field and freezes the activity bits while it is asserted.

Top module: `clkdom_sleep_ctrl`

## Requirements
- R1: The register is 32 bits. Bits 1:0 hold the control field. Bit 8 is the activity bit of clock 0 and bit 9 that of clock 1. Every other bit reads 0, whatever was written to it.
- R2: Control codes are 0 = stay-on, 1 = force-off, 2 = force-on. After a cold reset the field reads 2, the state machine is in the starting phase and every gate_en bit is 1.
- R3: A write of code 3 is ignored, and the field keeps its previous value.
- R4: With the domain running, a write of force-off makes gate_en fall to all zeros one cycle after the write edge. The stopping phase ends only when every gate_ack bit is 1.
- R5: In stay-on mode a running domain never starts to stop. An idle domain in stay-on mode starts waking.
- R6: When the domain is idle and the field is force-on, the domain wakes: gate_en rises to all ones one cycle after the domain reaches idle. The starting phase ends only when every ungate_ack bit is 1.
- R7: An activity bit reads 1 while the domain is running, stopping or starting, and reads 0 only in the idle state. It changes on the same edge as the state.
- R8: A mode written during a stopping or starting phase is stored at once, but it is acted on only after that phase completes. A phase is never abandoned part-way.
- R9: While warm_rst_n is low, gate_en is all ones at once, the control field is unchanged and the activity bits hold their value. The first edge after release updates the activity bits.
- R10: A cold reset clears the activity bits to 0 and sets the control field back to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset, clears all state |
| warm_rst_n | input | 1 | Asynchronous active-low warm reset, resets only the state machine |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| gate_en | output | 2 | Per-clock enable to the gating cells, 1 = clock allowed to run |
| gate_ack | input | 2 | Per-clock level, 1 = clock confirmed stopped |
| ungate_ack | input | 2 | Per-clock level, 1 = clock confirmed running |

## Verification
A register write takes effect on its own edge, so the control field reads back one cycle after the write edge. The mode is seen by the state machine on the next edge, so gate_en changes two edges after the write is presented. The activity bits follow the state on the same edge, and a warm reset moves gate_en with no clock at all.

The directed tests drive the acknowledges by hand and sample one time unit after each edge, at exactly these counts. This pins the single idle cycle between a completed stop and a wake that was latched mid-stop. The table-driven part lets a bench model of the gating cells answer after fixed latencies. It checks only after twelve cycles, once every transition has settled.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
   // Control field codes (register bits 1:0)
   typedef enum logic [1:0] {
      MODE_STAY_ON   = 2'd0,
      MODE_FORCE_OFF = 2'd1,
      MODE_FORCE_ON  = 2'd2,
      MODE_RSVD      = 2'd3
   } dom_mode_e;

   // Domain transition states
   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_STOPPING = 2'd1,
      ST_IDLE     = 2'd2,
      ST_STARTING = 2'd3
   } dom_state_e;
endpackage

// File: rtl/clkdom_mode_reg.sv
module clkdom_mode_reg
   import clkdom_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   output logic [MODE_W-1:0] mode_q
);
   localparam logic [MODE_W-1:0] RST_MODE = MODE_W'(MODE_FORCE_ON);
   localparam logic [MODE_W-1:0] BAD_MODE = MODE_W'(MODE_RSVD);

   if (MODE_W != 2) begin : g_bad_w
      $error("clkdom_mode_reg: MODE_W must be 2");
   end

   // Cold reset only: the field survives a warm reset (R9, R10)
   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)
         mode_q <= RST_MODE;
      else if (wr_en && (wr_mode != BAD_MODE))
         mode_q <= wr_mode;
   end

   a_r3_rsvd_ignored: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (wr_en && wr_mode == BAD_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/clkdom_fsm.sv
module clkdom_fsm
   import clkdom_pkg::*;
#(
   parameter int NCLK = 2
) (
   input  logic            clk,
   input  logic            cold_rst_n,
   input  logic            warm_rst_n,
   input  logic [1:0]      mode,
   input  logic [NCLK-1:0] gate_ack,
   input  logic [NCLK-1:0] ungate_ack,
   output dom_state_e      state_q,
   output dom_state_e      state_d,
   output logic [NCLK-1:0] gate_en
);
   logic all_stopped, all_running, clocks_on;

   assign all_stopped = &gate_ack;
   assign all_running = &ungate_ack;

   // Mode is sampled only in settled states, so a change written
   // mid-transition waits for the phase to end (R8)
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:      if (mode == MODE_FORCE_OFF) state_d = ST_STOPPING;
         ST_STOPPING: if (all_stopped)            state_d = ST_IDLE;
         ST_IDLE:     if (mode == MODE_FORCE_ON || mode == MODE_STAY_ON)
                         state_d = ST_STARTING;
         ST_STARTING: if (all_running)            state_d = ST_RUN;
         default:     state_d = ST_STARTING;
      endcase
   end

   // Either reset lands in the starting phase: the domain comes up awake
   always_ff @(posedge clk or negedge cold_rst_n or negedge warm_rst_n) begin
      if (!cold_rst_n || !warm_rst_n)
         state_q <= ST_STARTING;
      else
         state_q <= state_d;
   end

   assign clocks_on = (state_q == ST_RUN) || (state_q == ST_STARTING);

   for (genvar i = 0; i < NCLK; i++) begin : g_en
      assign gate_en[i] = clocks_on;
   end

   a_r5_stay_on_holds: assert property (@(posedge clk)
      disable iff (!cold_rst_n || !warm_rst_n)
      (state_q == ST_RUN && mode != MODE_FORCE_OFF) |=> state_q == ST_RUN);

   a_r4_stop_waits_ack: assert property (@(posedge clk)
      disable iff (!cold_rst_n || !warm_rst_n)
      (state_q == ST_STOPPING && !all_stopped) |=> state_q == ST_STOPPING);

   a_r6_start_waits_ack: assert property (@(posedge clk)
      disable iff (!cold_rst_n || !warm_rst_n)
      (state_q == ST_STARTING && !all_running) |=> state_q == ST_STARTING);

   a_r8_stop_not_abandoned: assert property (@(posedge clk)
      disable iff (!cold_rst_n || !warm_rst_n)
      (state_q == ST_STOPPING) |=> (state_q == ST_STOPPING || state_q == ST_IDLE));
endmodule

// File: rtl/clkdom_status.sv
module clkdom_status #(
   parameter int NCLK = 2
) (
   input  logic            clk,
   input  logic            cold_rst_n,
   input  logic            warm_rst_n,
   input  logic            idle_next,
   output logic [NCLK-1:0] act_q
);
   // One activity flop per clock, cleared by cold reset only and
   // frozen while warm reset is held (R9, R10)
   for (genvar i = 0; i < NCLK; i++) begin : g_act
      always_ff @(posedge clk or negedge cold_rst_n) begin
         if (!cold_rst_n)
            act_q[i] <= 1'b0;
         else if (warm_rst_n)
            act_q[i] <= !idle_next;
      end
   end

   a_r9_act_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !warm_rst_n |=> $stable(act_q));
endmodule

// File: rtl/clkdom_sleep_ctrl.sv
module clkdom_sleep_ctrl
   import clkdom_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NCLK    = 2,
   parameter int MODE_W  = 2,
   parameter int ACT_LSB = 8
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NCLK-1:0]   gate_en,
   input  logic [NCLK-1:0]   gate_ack,
   input  logic [NCLK-1:0]   ungate_ack
);
   localparam int ACT_MSB = ACT_LSB + NCLK - 1;

   if (NCLK < 1 || ACT_LSB < MODE_W || ACT_MSB >= DATA_W) begin : g_bad_map
      $error("clkdom_sleep_ctrl: activity bits do not fit the register");
   end

   logic [MODE_W-1:0] mode_q;
   logic [NCLK-1:0]   act_q;
   dom_state_e        state_q, state_d;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:MODE_W];

   clkdom_mode_reg #(.MODE_W(MODE_W)) u_mode (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .wr_en      (reg_wr_en),
      .wr_mode    (reg_wdata[MODE_W-1:0]),
      .mode_q     (mode_q)
   );

   clkdom_fsm #(.NCLK(NCLK)) u_fsm (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst_n (warm_rst_n),
      .mode       (mode_q),
      .gate_ack   (gate_ack),
      .ungate_ack (ungate_ack),
      .state_q    (state_q),
      .state_d    (state_d),
      .gate_en    (gate_en)
   );

   clkdom_status #(.NCLK(NCLK)) u_stat (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst_n (warm_rst_n),
      .idle_next  (state_d == ST_IDLE),
      .act_q      (act_q)
   );

   always_comb begin
      reg_rdata = '0;
      reg_rdata[MODE_W-1:0]     = mode_q;
      reg_rdata[ACT_MSB:ACT_LSB] = act_q;
   end

   // R7: a clock allowed to run always reads as active, except while
   // warm reset holds the activity bits
   a_r7_enabled_is_active: assert property (@(posedge clk)
      disable iff (!cold_rst_n || !warm_rst_n)
      (state_q == ST_RUN) |-> (&act_q));
endmodule

// File: tb/sim_clkdom_sleep_ctrl.sv
module sim_clkdom_sleep_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0;
   logic        warm_rst_n = 1'b1;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  gate_en, gate_ack, ungate_ack;

   logic        auto_ack = 1'b0;
   logic [1:0]  gack_man = 2'b00, uack_man = 2'b00;
   logic [3:0]  sr0 = '0, sr1 = '0;
   logic [1:0]  gack_auto;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Gating cell model: clock 0 answers after 1 cycle, clock 1 after 3
   always @(posedge clk) begin
      sr0 <= {sr0[2:0], ~gate_en[0]};
      sr1 <= {sr1[2:0], ~gate_en[1]};
   end
   assign gack_auto  = {sr1[2], sr0[0]};
   assign gate_ack   = auto_ack ? gack_auto  : gack_man;
   assign ungate_ack = auto_ack ? ~gack_auto : uack_man;

   clkdom_sleep_ctrl u0 (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .gate_en(gate_en), .gate_ack(gate_ack), .ungate_ack(ungate_ack)
   );

   typedef struct packed {
      logic [31:0] wdata;
      logic [1:0]  en;
      logic [31:0] rdata;
   } vec_t;

   // Rows: write, then after settling expect gate_en and full read word
   localparam vec_t VECS [8] = '{
      '{32'h0000_0001, 2'b00, 32'h0000_0001},
      '{32'h0000_0003, 2'b00, 32'h0000_0001},
      '{32'h0000_0000, 2'b11, 32'h0000_0300},
      '{32'hFFFF_FFFD, 2'b00, 32'h0000_0001},
      '{32'h0000_0002, 2'b11, 32'h0000_0302},
      '{32'h0000_0000, 2'b11, 32'h0000_0300},
      '{32'h0000_0303, 2'b11, 32'h0000_0300},
      '{32'hABCD_0001, 2'b00, 32'h0000_0001}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] v);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      tick(1);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // ---- cold reset, manual acknowledges
      tick(3);
      cold_rst_n = 1'b1;
      chk("R2 R10 reset read word", reg_rdata, 32'h2);
      chk("R2 reset gate_en", {30'b0, gate_en}, 32'h3);
      tick(3);
      chk("R6 R7 starting waits, active", reg_rdata, 32'h302);
      uack_man = 2'b01;
      tick(2);
      chk("R6 partial ungate ack keeps enables", {30'b0, gate_en}, 32'h3);
      uack_man = 2'b11;
      tick(1);                          // now running
      uack_man = 2'b00;

      // ---- force-off with partial acknowledge, wake latched mid-stop
      wr(32'h1);
      chk("R4 still enabled on write edge", {30'b0, gate_en}, 32'h3);
      tick(1);
      chk("R4 enables drop", {30'b0, gate_en}, 32'h0);
      chk("R7 active while stopping", reg_rdata, 32'h301);
      gack_man = 2'b01;
      tick(3);
      chk("R4 partial gate ack holds stop", reg_rdata, 32'h301);
      wr(32'h2);
      chk("R8 mode stored mid-stop, still stopping", reg_rdata, 32'h302);
      chk("R8 enables stay off mid-stop", {30'b0, gate_en}, 32'h0);
      gack_man = 2'b11;
      tick(1);
      chk("R7 R8 idle one cycle", reg_rdata, 32'h002);
      tick(1);
      chk("R6 R8 wake after stop done", {30'b0, gate_en}, 32'h3);
      chk("R7 active while starting", reg_rdata, 32'h302);
      gack_man = 2'b00;
      uack_man = 2'b11;
      tick(1);
      uack_man = 2'b00;

      // ---- warm reset from idle
      wr(32'h1);
      tick(1);
      gack_man = 2'b11;
      tick(3);
      chk("R7 idle reads inactive", reg_rdata, 32'h001);
      warm_rst_n = 1'b0;
      #1;
      chk("R9 warm reset enables at once", {30'b0, gate_en}, 32'h3);
      gack_man = 2'b00;
      tick(2);
      chk("R9 field kept, activity frozen", reg_rdata, 32'h001);
      warm_rst_n = 1'b1;
      tick(1);
      chk("R9 activity updates after release", reg_rdata, 32'h301);
      uack_man = 2'b11;
      tick(1);
      uack_man = 2'b00;
      tick(1);
      chk("R9 kept force-off acts after warm reset", {30'b0, gate_en}, 32'h0);
      gack_man = 2'b11;
      tick(1);
      wr(32'h0);
      tick(1);
      chk("R5 stay-on wakes idle domain", {30'b0, gate_en}, 32'h3);
      gack_man = 2'b00;

      // ---- cold reset while active, then table with the cell model
      auto_ack = 1'b1;
      tick(12);
      chk("R5 stay-on keeps running", reg_rdata, 32'h300);
      cold_rst_n = 1'b0;
      #1;
      chk("R10 cold reset clears activity and field", reg_rdata, 32'h2);
      tick(1);
      cold_rst_n = 1'b1;
      tick(12);
      chk("R2 settled after cold reset", reg_rdata, 32'h302);

      for (int i = 0; i < 8; i++) begin
         wr(VECS[i].wdata);
         tick(12);
         // R1 R3 R4 R5 R6 R7: table row
         chk($sformatf("R1 R3 R5 table row %0d read word", i), reg_rdata, VECS[i].rdata);
         chk($sformatf("R4 R6 table row %0d gate_en", i), {30'b0, gate_en},
             {30'b0, VECS[i].en});
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule